// File: doc/BRIEF.md
# Banked Indirect Test-Register Access Unit

This block is a 32-entry register file of 16-bit words. A management front end drives it through a plain register write port and a combinational read port. Most addresses are ordinary storage. Three of them form a window onto hidden banks of test registers. The first is a command register. The second is a read-data register that software can only read. The third is a staging register that holds the word to be written.

A write command copies the staged word into a banked register, chosen by a bank code and a write address. A read command fetches a banked register, chosen by a bank code and a read address, into the read-data register. Two banks hold real storage: an analog/DSP bank (code 0) and a self-test bank (code 3). The self-test bank contains PLL control and divider words.

Commands are refused until software unlocks the window. It does this with four command-register writes of exact values, made in a fixed order. After a command, the request bits clear themselves.

Top module: `test_reg_access`

## Requirements
- R1: After reset every direct address reads 0x0000, the window is locked and every banked register holds 0x0000.
- R2: Direct addresses other than 20, 21 and 23 keep the last written word. Writes to address 21 have no effect on what it reads back.
- R3: Address 20 reads back the last word written to it, except that bits 15 (read request) and 14 (write request) always read 0.
- R4: The window unlocks after four writes to address 20 with the exact values 0x0000, 0x0400, 0x0000 and 0x0400. While it is locked, commands are dropped.
- R5: While the window is not fully unlocked, any write to address 20 that does not match the next expected value returns the unlock tracker to its starting state. While it is unlocked, a write to address 20 with bit 10 clear locks it again.
- R6: A command is carried out only if the window was already unlocked before the write and bit 10 is set in the same write.
- R7: A write command (bit 14 set) copies the word at address 23 into the bank selected by bits 12:11, at the address given by bits 4:0.
- R8: A read command (bit 15 set) loads the banked register selected by bits 12:11 and bits 9:5 into address 21. The value is readable in the cycle after the command write and stays until the next read command.
- R9: Bank codes 1 and 2 have no storage. Write commands to them are dropped, and read commands to them load 0x0000.
- R10: A command with both request bits set returns the value that the addressed register held before the write in the same command.
- R11: Each bank has its own registers, so the same address in bank 0 and bank 3 holds separate values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the direct register port |
| addr_i | input | 5 | Direct register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the addressed direct register, combinational |

## Verification
The unlock tracker is never visible at the ports, so the bench has to infer its state. It stages a known word into address 21 with an accepted read command. It then sends a command, and if address 21 still holds the staged word, the command was refused. The bench uses this to probe three cases: a sequence broken partway, a relock caused by a command with bit 10 clear, and an unlock performed while the window is open. Banked contents are observed only through read commands. Each write is therefore followed by reads from the same bank, from another bank, and from the banks with no storage.

// File: rtl/tra_pkg.sv
package tra_pkg;
  typedef enum logic [2:0] {
    UL_IDLE,
    UL_ZERO1,
    UL_TEST1,
    UL_ZERO2,
    UL_OPEN
  } unlock_e;

  // command register field positions
  localparam int RD_BIT  = 15;
  localparam int WR_BIT  = 14;
  localparam int BANK_HI = 12;
  localparam int BANK_LO = 11;
  localparam int TM_BIT  = 10;
  localparam int RA_HI   = 9;
  localparam int RA_LO   = 5;
  localparam int WA_HI   = 4;
  localparam int WA_LO   = 0;
endpackage

// File: rtl/tra_unlock.sv
module tra_unlock
  import tra_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] ctrl_wdata_i,
  output logic              open_o
);
  localparam logic [DATA_W-1:0] ZERO_W = '0;
  localparam logic [DATA_W-1:0] TEST_W = DATA_W'(1) << TM_BIT;

  unlock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ctrl_we_i) begin
      unique case (state_q)
        UL_IDLE:  state_d = (ctrl_wdata_i == ZERO_W) ? UL_ZERO1 : UL_IDLE;
        UL_ZERO1: state_d = (ctrl_wdata_i == TEST_W) ? UL_TEST1 : UL_IDLE;
        UL_TEST1: state_d = (ctrl_wdata_i == ZERO_W) ? UL_ZERO2 : UL_IDLE;
        UL_ZERO2: state_d = (ctrl_wdata_i == TEST_W) ? UL_OPEN  : UL_IDLE;
        UL_OPEN:  state_d = ctrl_wdata_i[TM_BIT]     ? UL_OPEN  : UL_IDLE;
        default:  state_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= UL_IDLE;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == UL_OPEN);
endmodule

// File: rtl/tra_bank.sv
module tra_bank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter bit IMPL   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  if (IMPL) begin : g_store
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i) begin
        mem_q[waddr_i] <= wdata_i;
      end
    end

    assign rdata_o = mem_q[raddr_i];
  end else begin : g_hole
    // absent bank: drop writes, read zero
    logic unused_ok;
    assign unused_ok = ^{clk_i, rst_ni, we_i, waddr_i, wdata_i, raddr_i};
    assign rdata_o   = '0;
  end
endmodule

// File: rtl/test_reg_access.sv
module test_reg_access
  import tra_pkg::*;
#(
  parameter int         DATA_W      = 16,
  parameter int         ADDR_W      = 5,
  parameter int         BANK_W      = 2,
  parameter logic [3:0] BANK_IMPL   = 4'b1001,
  parameter int         CTRL_ADDR   = 20,
  parameter int         RDATA_ADDR  = 21,
  parameter int         WSTAGE_ADDR = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int NBANKS  = 1 << BANK_W;
  localparam int BADDR_W = RA_HI - RA_LO + 1;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [DATA_W-1:0] REQ_MASK =
    (DATA_W'(1) << RD_BIT) | (DATA_W'(1) << WR_BIT);

  logic [DATA_W-1:0] view_w [DEPTH];
  logic [DATA_W-1:0] bank_rd [NBANKS];
  logic [DATA_W-1:0] rd_q;
  logic              ctrl_we, unlocked, cmd_ok, bank_we, rd_cmd;
  logic [BANK_W-1:0] bank_sel;
  logic [BADDR_W-1:0] raddr, waddr;

  assign ctrl_we  = we_i && (addr_i == CTRL_A);
  assign cmd_ok   = ctrl_we && unlocked && wdata_i[TM_BIT];
  assign bank_we  = cmd_ok && wdata_i[WR_BIT];
  assign rd_cmd   = cmd_ok && wdata_i[RD_BIT];
  assign bank_sel = wdata_i[BANK_HI:BANK_LO];
  assign raddr    = wdata_i[RA_HI:RA_LO];
  assign waddr    = wdata_i[WA_HI:WA_LO];

  tra_unlock #(.DATA_W(DATA_W)) u_unlock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we),
    .ctrl_wdata_i (wdata_i),
    .open_o       (unlocked)
  );

  // direct register file
  for (genvar i = 0; i < DEPTH; i++) begin : g_dir
    if (i == RDATA_ADDR) begin : g_rdata
      assign view_w[i] = rd_q;
    end else if (i == CTRL_ADDR) begin : g_ctrl
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (ctrl_we) q <= wdata_i & ~REQ_MASK;
      end
      assign view_w[i] = q;
    end else begin : g_plain
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              q <= '0;
        else if (we_i && addr_i == ADDR_W'(i))    q <= wdata_i;
      end
      assign view_w[i] = q;
    end
  end

  // hidden banks
  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    tra_bank #(
      .DATA_W (DATA_W),
      .ADDR_W (BADDR_W),
      .IMPL   (BANK_IMPL[b])
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we && bank_sel == BANK_W'(b)),
      .waddr_i (waddr),
      .wdata_i (view_w[WSTAGE_ADDR]),
      .raddr_i (raddr),
      .rdata_o (bank_rd[b])
    );
  end

  // read capture sees the pre-write bank contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_q <= '0;
    else if (rd_cmd) rd_q <= bank_rd[bank_sel];
  end

  assign rdata_o = view_w[addr_i];
endmodule

// File: rtl/test_reg_access_chk.sv
module test_reg_access_chk #(
  parameter int         DATA_W     = 16,
  parameter int         ADDR_W     = 5,
  parameter int         BANK_W     = 2,
  parameter logic [3:0] BANK_IMPL  = 4'b1001,
  parameter int         CTRL_ADDR  = 20,
  parameter int         RDATA_ADDR = 21
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              unlocked,
  input logic              bank_we,
  input logic              rd_cmd,
  input logic [BANK_W-1:0] bank_sel,
  input logic [DATA_W-1:0] rd_q
);
  assert_ro_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(RDATA_ADDR)) |=> $stable(rd_q));

  assert_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we || rd_cmd) |-> unlocked);

  assert_relock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(CTRL_ADDR) && !wdata_i[10]) |=> !unlocked);

  assert_tm_same_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we || rd_cmd) |-> (we_i && addr_i == ADDR_W'(CTRL_ADDR) && wdata_i[10]));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_cmd |=> $stable(rd_q));

  assert_hole_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd && !BANK_IMPL[bank_sel]) |=> (rd_q == '0));
endmodule

bind test_reg_access test_reg_access_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .BANK_W     (BANK_W),
  .BANK_IMPL  (BANK_IMPL),
  .CTRL_ADDR  (CTRL_ADDR),
  .RDATA_ADDR (RDATA_ADDR)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .unlocked (unlocked),
  .bank_we  (bank_we),
  .rd_cmd   (rd_cmd),
  .bank_sel (bank_sel),
  .rd_q     (rd_q)
);

// File: tb/test_reg_access_test.sv
module test_reg_access_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [4:0]  a;
    logic [15:0] e;
    string       tag;
  } item_t;
  item_t sb_q[$];

  test_reg_access uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  always #10 clk_i = ~clk_i; // 50 MHz

  // monitor: pops expected items and compares mid-cycle
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rdata_o !== it.e) begin
        errors++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, rdata_o, it.e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    we_i = 1'b0;
  endtask

  task automatic chk(input logic [4:0] a, input logic [15:0] e, input string tag);
    item_t it;
    addr_i = a;
    it.a = a; it.e = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk_i); #1;
  endtask

  task automatic unlock();
    wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0000); wr(20, 16'h0400);
  endtask

  function automatic logic [15:0] rcmd(input logic [1:0] b, input logic [4:0] a);
    return 16'h8400 | (16'(b) << 11) | (16'(a) << 5);
  endfunction

  function automatic logic [15:0] wcmd(input logic [1:0] b, input logic [4:0] a);
    return 16'h4400 | (16'(b) << 11) | 16'(a);
  endfunction

  task automatic bwrite(input logic [1:0] b, input logic [4:0] a, input logic [15:0] d);
    wr(23, d); wr(20, wcmd(b, a));
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // R1 reset state
    chk(0, 16'h0000, "R1");
    chk(20, 16'h0000, "R1");
    chk(21, 16'h0000, "R1");
    chk(23, 16'h0000, "R1");

    // R2 plain storage, address 21 read-only
    wr(5, 16'h1234);   chk(5, 16'h1234, "R2");
    wr(31, 16'hbeef);  chk(31, 16'hbeef, "R2");
    wr(21, 16'hffff);  chk(21, 16'h0000, "R2");

    // R3 request bits read as 0
    wr(20, 16'hC123);  chk(20, 16'h0123, "R3");

    // R4 command while locked is dropped
    bwrite(2'd0, 5'h17, 16'h5555);
    unlock();
    wr(20, rcmd(2'd0, 5'h17));
    chk(21, 16'h0000, "R4");

    // R7 write then read back, R8 next-cycle visibility
    bwrite(2'd0, 5'h17, 16'h8e0d);
    wr(20, rcmd(2'd0, 5'h17));
    chk(21, 16'h8e0d, "R7_R8");
    chk(20, 16'h06E0, "R3");

    bwrite(2'd3, 5'h1b, 16'h0005);
    bwrite(2'd3, 5'h1d, 16'h029a);
    bwrite(2'd3, 5'h1c, 16'haaaa);
    wr(20, rcmd(2'd3, 5'h1d)); chk(21, 16'h029a, "R7");
    wr(20, rcmd(2'd3, 5'h1c)); chk(21, 16'haaaa, "R7");

    // R11 bank separation at same address
    bwrite(2'd0, 5'h1b, 16'h1111);
    wr(20, rcmd(2'd3, 5'h1b)); chk(21, 16'h0005, "R11");
    wr(20, rcmd(2'd0, 5'h1b)); chk(21, 16'h1111, "R11");

    // R8 hold across unrelated writes
    wr(23, 16'h7777); wr(5, 16'h2222); wr(20, 16'h0400);
    chk(21, 16'h1111, "R8");

    // R6 command without test-mode bit dropped, and relocks (R5)
    wr(23, 16'h3333);
    wr(20, 16'h4017);
    wr(20, rcmd(2'd3, 5'h1b));
    chk(21, 16'h1111, "R5");
    unlock();
    wr(20, rcmd(2'd0, 5'h17));
    chk(21, 16'h8e0d, "R6");

    // R5 broken sequence leaves window locked
    wr(20, rcmd(2'd3, 5'h1b)); chk(21, 16'h0005, "R5");
    wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0001); wr(20, 16'h0400);
    wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0000);
    wr(20, rcmd(2'd0, 5'h17));
    chk(21, 16'h0005, "R5");

    // R9 banks without storage
    unlock();
    bwrite(2'd1, 5'h1b, 16'h4444);
    wr(20, rcmd(2'd3, 5'h1b)); chk(21, 16'h0005, "R9");
    wr(20, rcmd(2'd1, 5'h1b)); chk(21, 16'h0000, "R9");
    wr(20, rcmd(2'd3, 5'h1b)); chk(21, 16'h0005, "R9");
    bwrite(2'd2, 5'h1b, 16'h4444);
    wr(20, rcmd(2'd2, 5'h1b)); chk(21, 16'h0000, "R9");

    // R10 combined read and write returns old value
    wr(23, 16'h9999);
    wr(20, rcmd(2'd3, 5'h1c) | wcmd(2'd3, 5'h1c));
    chk(21, 16'haaaa, "R10");
    wr(20, rcmd(2'd3, 5'h1c));
    chk(21, 16'h9999, "R10");

    repeat (2) @(posedge clk_i);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule